// File: doc/BRIEF.md
# Descriptor Side-Data Word Stack

This block keeps account of a small per-packet scratch area made of 32-bit words that rides along with a packet descriptor. Callers claim space in whole words. Each claim is carved downward from the top end of the area, so the newest claim always occupies the lowest word indices taken so far. The block only tracks how many words are taken. It does not store word contents.

A second port answers alignment questions. Given a byte alignment, the block reports how many padding bytes separate the current used size from that alignment, or flags the query as invalid. A clear input empties the area when a new packet begins. All answers are registered and appear on the cycle after the request.

Top module: `sdw_stack`

## Requirements
- R1: A push whose byte count has either of bits [1:0] set is rejected (push_ok_o=0, push_idx_o=0) and leaves the used-word count unchanged.
- R2: An accepted push adds its byte count divided by four to the used-word count; a zero-byte push is accepted and adds nothing.
- R3: A push is rejected, with the count unchanged, when the used words plus the new words would be more than CAP_WORDS (default 16).
- R4: An accepted push returns push_idx_o = CAP_WORDS minus the used count after the push.
- R5: An alignment value of 0 returns algn_bad_o=1 and algn_pad_o=0.
- R6: Alignment values 1, 2 and 4 return algn_bad_o=0 and algn_pad_o=0.
- R7: Any other alignment value returns (used words x 4) modulo the alignment, with algn_bad_o=0.
- R8: Reset or clear_i sets the used count to zero. A push in the same cycle as clear_i is rejected.
- R9: push_done_o and algn_done_o pulse high exactly one cycle after push_vld_i or algn_vld_i. A query in the same cycle as a push, or as a clear, sees the count from before that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| clear_i | input | 1 | Empty the area for a new packet |
| push_vld_i | input | 1 | Push request strobe |
| push_bytes_i | input | BYTE_W | Bytes requested |
| push_done_o | output | 1 | Push response valid |
| push_ok_o | output | 1 | Push accepted |
| push_idx_o | output | USED_W | Starting word index of the accepted claim |
| algn_vld_i | input | 1 | Alignment query strobe |
| algn_val_i | input | ALGN_W | Requested byte alignment |
| algn_done_o | output | 1 | Query response valid |
| algn_bad_o | output | 1 | Query invalid (alignment zero) |
| algn_pad_o | output | ALGN_W | Padding byte count |

## Verification
A push and an alignment query can arrive in the same cycle. A clear can also arrive in the same cycle as either one. The bench issues a query with every push during long fill sequences. It expects the padding to come from the count before the push, and it reads the count after the push on the next query. Clear plus push is driven once and judged by a rejected push, followed by a query that shows zero used words.

// File: rtl/sdw_pkg.sv
package sdw_pkg;
  typedef enum logic [1:0] {
    ALGN_ZERO    = 2'd0,
    ALGN_TRIVIAL = 2'd1,
    ALGN_MOD     = 2'd2
  } algn_kind_e;
endpackage

// File: rtl/sdw_claim.sv
module sdw_claim #(
  parameter int unsigned CAP_WORDS = 16,
  parameter int unsigned BYTE_W    = 8,
  parameter int unsigned USED_W    = 5
) (
  input  logic [USED_W-1:0] used_i,
  input  logic [BYTE_W-1:0] bytes_i,
  output logic              ok_o,
  output logic [USED_W-1:0] new_used_o,
  output logic [USED_W-1:0] idx_o
);
  localparam int unsigned SUM_W = ((BYTE_W > USED_W) ? BYTE_W : USED_W) + 1;

  logic [SUM_W-1:0] words, sum;
  logic             aligned, fits;

  always_comb begin
    words      = SUM_W'(bytes_i >> 2);
    sum        = SUM_W'(used_i) + words;
    aligned    = (bytes_i[1:0] == 2'b00);
    fits       = (sum <= SUM_W'(CAP_WORDS));
    ok_o       = aligned && fits;
    new_used_o = ok_o ? sum[USED_W-1:0] : used_i;
    idx_o      = ok_o ? (USED_W'(CAP_WORDS) - sum[USED_W-1:0]) : '0;
  end
endmodule

// File: rtl/sdw_pad.sv
module sdw_pad
  import sdw_pkg::*;
#(
  parameter int unsigned USED_W = 5,
  parameter int unsigned ALGN_W = 8
) (
  input  logic [USED_W-1:0] used_i,
  input  logic [ALGN_W-1:0] algn_i,
  output logic              bad_o,
  output logic [ALGN_W-1:0] pad_o
);
  localparam int unsigned MW = ((USED_W + 2) > ALGN_W) ? (USED_W + 2) : ALGN_W;

  algn_kind_e    kind;
  logic [MW-1:0] used_bytes, rem;

  always_comb begin
    if (algn_i == '0)                                      kind = ALGN_ZERO;
    else if (algn_i == ALGN_W'(1) || algn_i == ALGN_W'(2) ||
             algn_i == ALGN_W'(4))                         kind = ALGN_TRIVIAL;
    else                                                   kind = ALGN_MOD;
  end

  always_comb begin
    used_bytes = MW'({used_i, 2'b00});
    rem        = '0;
    if (kind == ALGN_MOD) rem = used_bytes % MW'(algn_i);
  end

  assign bad_o = (kind == ALGN_ZERO);
  assign pad_o = rem[ALGN_W-1:0];
endmodule

// File: rtl/sdw_stack.sv
module sdw_stack
  import sdw_pkg::*;
#(
  parameter int unsigned CAP_WORDS = 16,
  parameter int unsigned BYTE_W    = 8,
  parameter int unsigned ALGN_W    = 8,
  localparam int unsigned USED_W   = $clog2(CAP_WORDS + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              push_vld_i,
  input  logic [BYTE_W-1:0] push_bytes_i,
  output logic              push_done_o,
  output logic              push_ok_o,
  output logic [USED_W-1:0] push_idx_o,
  input  logic              algn_vld_i,
  input  logic [ALGN_W-1:0] algn_val_i,
  output logic              algn_done_o,
  output logic              algn_bad_o,
  output logic [ALGN_W-1:0] algn_pad_o
);
  logic [USED_W-1:0] used_q;
  logic              claim_ok;
  logic [USED_W-1:0] claim_used, claim_idx;
  logic              pad_bad;
  logic [ALGN_W-1:0] pad_val;

  sdw_claim #(.CAP_WORDS(CAP_WORDS), .BYTE_W(BYTE_W), .USED_W(USED_W)) u_claim (
    .used_i    (used_q),
    .bytes_i   (push_bytes_i),
    .ok_o      (claim_ok),
    .new_used_o(claim_used),
    .idx_o     (claim_idx)
  );

  // query sees the count as it stood before this cycle
  sdw_pad #(.USED_W(USED_W), .ALGN_W(ALGN_W)) u_pad (
    .used_i(used_q),
    .algn_i(algn_val_i),
    .bad_o (pad_bad),
    .pad_o (pad_val)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      used_q      <= '0;
      push_done_o <= 1'b0;
      push_ok_o   <= 1'b0;
      push_idx_o  <= '0;
    end else begin
      push_done_o <= push_vld_i;
      if (clear_i) begin
        used_q     <= '0;
        push_ok_o  <= 1'b0;
        push_idx_o <= '0;
      end else if (push_vld_i) begin
        used_q     <= claim_used;
        push_ok_o  <= claim_ok;
        push_idx_o <= claim_idx;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      algn_done_o <= 1'b0;
      algn_bad_o  <= 1'b0;
      algn_pad_o  <= '0;
    end else begin
      algn_done_o <= algn_vld_i;
      if (algn_vld_i) begin
        algn_bad_o <= pad_bad;
        algn_pad_o <= pad_val;
      end
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    used_q <= USED_W'(CAP_WORDS)); // R3
  AST_UNALIGNED_NOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_vld_i && !clear_i && push_bytes_i[1:0] != 2'b00) |=> (used_q == $past(used_q) && !push_ok_o)); // R1
  AST_IDX_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_done_o && push_ok_o) |-> (push_idx_o == USED_W'(CAP_WORDS) - used_q)); // R4
  AST_ZERO_ALIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (algn_vld_i && algn_val_i == '0) |=> (algn_bad_o && algn_pad_o == '0)); // R5
  AST_PAD_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (algn_vld_i && algn_val_i != '0) |=> (!algn_bad_o && algn_pad_o < $past(algn_val_i))); // R7
  AST_CLEAR_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (used_q == '0)); // R8
  AST_DONE_LAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_vld_i |=> push_done_o); // R9
endmodule

// File: tb/sdw_stack_tb_top.sv
module sdw_stack_tb_top;
  localparam int CAP = 16;
  localparam int UW  = $clog2(CAP + 1);

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       clear = 1'b0, pvld = 1'b0, avld = 1'b0;
  logic [7:0] pbytes = '0, aval = '0;
  logic       pdone, pok, adone, abad;
  logic [UW-1:0] pidx;
  logic [7:0] apad;

  int n_run = 0, n_fail = 0, m_used = 0;
  bit done_flag = 0;

  always #10 clk = ~clk;

  sdw_stack #(.CAP_WORDS(CAP), .BYTE_W(8), .ALGN_W(8)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .clear_i(clear),
    .push_vld_i(pvld), .push_bytes_i(pbytes), .push_done_o(pdone),
    .push_ok_o(pok), .push_idx_o(pidx),
    .algn_vld_i(avld), .algn_val_i(aval), .algn_done_o(adone),
    .algn_bad_o(abad), .algn_pad_o(apad)
  );

  task automatic chk(input bit cond, input string req, input int act, input int exp);
    n_run++;
    if (!cond) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input bit c, input bit pv, input int b, input bit av, input int a);
    bit e_ok; int e_idx, e_pad, nw; string tp, ta;
    @(negedge clk);
    clear = c; pvld = pv; pbytes = 8'(b); avld = av; aval = 8'(a);
    @(posedge clk);
    #5;
    nw = b / 4;
    e_ok = pv && !c && (b % 4 == 0) && (m_used + nw <= CAP);
    e_idx = e_ok ? CAP - (m_used + nw) : 0;
    if (c) tp = "R8";
    else if (b % 4 != 0) tp = "R1";
    else if (m_used + nw > CAP) tp = "R3";
    else tp = "R2";
    chk(pdone == pv, "R9", int'(pdone), int'(pv));
    if (pv) begin
      chk(pok == e_ok, tp, int'(pok), int'(e_ok));
      chk(int'(pidx) == e_idx, e_ok ? "R4" : tp, int'(pidx), e_idx);
    end
    chk(adone == av, "R9", int'(adone), int'(av));
    if (av) begin
      if (a == 0) ta = "R5";
      else if (a == 1 || a == 2 || a == 4) ta = "R6";
      else ta = "R7";
      e_pad = (a == 0 || a == 1 || a == 2 || a == 4) ? 0 : (m_used * 4) % a;
      chk(abad == (a == 0), ta, int'(abad), int'(a == 0));
      chk(int'(apad) == e_pad, ta, int'(apad), e_pad);
    end
    if (c) m_used = 0;
    else if (e_ok) m_used += nw;
  endtask

  initial begin
    #3_000_000;
    if (!done_flag) begin
      n_fail++; n_run++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #5;
    chk(pdone == 0 && pok == 0 && pidx == 0, "R8", int'(pok), 0);
    chk(adone == 0 && abad == 0 && apad == 0, "R8", int'(apad), 0);
    @(negedge clk); rst_n = 1'b1;
    step(0, 0, 0, 1, 128);          // R8: empty after reset
    step(0, 0, 0, 0, 0);            // R9: idle, no done
    // R1 R2 R3 R4 R9: fill sequences with concurrent queries
    for (int b = 0; b < 23; b++) begin
      step(1, 0, 0, 0, 0);
      for (int k = 0; k < 7; k++) step(0, 1, b, 1, (b * 7 + k) % 23);
      step(0, 0, 0, 1, 128);
    end
    // R8: clear and push in the same cycle
    step(0, 1, 20, 0, 0);
    step(1, 1, 4, 1, 128);
    step(0, 0, 0, 1, 128);
    // R5 R6 R7: full alignment sweep at several fill levels
    for (int lvl = 0; lvl <= CAP; lvl += 3) begin
      step(1, 0, 0, 0, 0);
      step(0, 1, lvl * 4, 0, 0);
      for (int a = 0; a < 256; a++) step(0, 0, 0, 1, a);
    end
    // R3: exact fill then one more word
    step(1, 0, 0, 0, 0);
    step(0, 1, CAP * 4, 1, 0);
    step(0, 1, 4, 1, 3);
    step(0, 1, 0, 1, 7);
    done_flag = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule